// File: doc/BRIEF.md
# Gated Up/Down Integrating Pulse Counter

This block integrates a train of pulses over precisely timed windows. A rising edge on the pulse input stands for one fixed packet of charge. A pulse adds one to a signed accumulator while a signal window is open. It subtracts one while a background window is open. Outside the windows, pulses have no effect. Because the background is subtracted from the signal, the final sum is a background-corrected measure of the charge.

One start request runs a whole measurement. The block opens a signal window (counting up), then a background window (counting down), and repeats that pair a programmed number of times. It then latches the signed sum and raises a one-cycle done strobe. Both window lengths are given in reference-clock cycles. The result has no handshake and applies no back-pressure: it is a plain registered value. It stays valid from the done strobe until the next done strobe. If the sum would pass the signed limits of the accumulator, the count saturates and a sticky overflow flag is raised.

Top module: `gated_integrator`

## Requirements
- R1: A start request is accepted only in a cycle where busy is low. On the next clock edge, busy goes high, the accumulator is zero and the overflow flag is cleared.
- R2: Each signal window keeps gate and count-up high for exactly sig_len cycles. Each background window keeps gate high and count-up low for exactly bkg_len cycles. A length of 0 behaves as 1. Gate is never high while busy is low.
- R3: Each measurement runs a signal window followed by a background window, and repeats this pair pairs times. A pairs value of 0 behaves as 1.
- R4: The pulse input passes through a two-stage synchronizer. A 0-to-1 transition of the synchronized input adds 1 if the signal window is open on the edge where it is taken, and subtracts 1 if the background window is open on that edge. No pulse is counted twice, none is dropped at a window boundary, and none is counted while gate is low.
- R5: Pulses only two clock cycles apart (one cycle high, one cycle low) are each counted.
- R6: Done is high for exactly one cycle, two cycles after the last background cycle. In that same cycle result shows the final signed sum, and result holds that value until the next done.
- R7: If the sum would exceed the largest positive value or fall below the most negative value, it stays at that limit. The overflow flag then sets and remains set until the next accepted start.
- R8: A start request while busy is high is ignored. The running sum and the window sequence are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a measurement |
| sig_len_i | input | WIN_W | Signal window length in cycles, taken at start |
| bkg_len_i | input | WIN_W | Background window length in cycles, taken at start |
| pairs_i | input | REP_W | Number of signal/background pairs, taken at start |
| pulse_i | input | 1 | Pulse train from the converter, asynchronous |
| busy_o | output | 1 | A measurement is in progress |
| gate_o | output | 1 | A counting window is open |
| count_up_o | output | 1 | High in signal windows, low in background windows |
| done_o | output | 1 | One-cycle strobe when the result is latched |
| result_o | output | CNT_W | Signed background-corrected sum |
| overflow_o | output | 1 | Sticky saturation flag |

## Verification
The bench builds the block with an 8-bit accumulator and 12-bit window lengths. With these widths, both saturation limits (+127 and -128) can be reached in a few hundred cycles of dense pulses, so the saturation and sticky overflow behaviour is tested in both directions. It also runs pair counts from 1 to 20, including the 10 to 20 range used in practice. Window lengths of 0 and 1 are included, to test pulses that land on window boundaries.

// File: rtl/gated_integrator_pkg.sv
package gated_integrator_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SIG    = 2'd1,
    PH_BKG    = 2'd2,
    PH_FINISH = 2'd3
  } phase_e;
endpackage

// File: rtl/pulse_edge.sv
module pulse_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pulse_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pulse_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/window_seq.sv
module window_seq
  import gated_integrator_pkg::*;
#(
  parameter int WIN_W = 24,
  parameter int REP_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIN_W-1:0] sig_len_i,
  input  logic [WIN_W-1:0] bkg_len_i,
  input  logic [REP_W-1:0] pairs_i,
  output phase_e           phase_o,
  output logic             launch_o
);
  phase_e           phase_q;
  logic [WIN_W-1:0] timer_q;
  logic [WIN_W-1:0] sig_last_q, bkg_last_q;
  logic [REP_W-1:0] left_q;
  logic [WIN_W-1:0] sig_last, bkg_last;

  assign sig_last = (sig_len_i == '0) ? '0 : sig_len_i - 1'b1;
  assign bkg_last = (bkg_len_i == '0) ? '0 : bkg_len_i - 1'b1;
  assign launch_o = start_i && (phase_q == PH_IDLE);
  assign phase_o  = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      timer_q    <= '0;
      sig_last_q <= '0;
      bkg_last_q <= '0;
      left_q     <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (launch_o) begin
          phase_q    <= PH_SIG;
          timer_q    <= sig_last;
          sig_last_q <= sig_last;
          bkg_last_q <= bkg_last;
          left_q     <= (pairs_i == '0) ? REP_W'(1) : pairs_i;
        end
        PH_SIG: if (timer_q == '0) begin
          phase_q <= PH_BKG;
          timer_q <= bkg_last_q;
        end else begin
          timer_q <= timer_q - 1'b1;
        end
        PH_BKG: if (timer_q == '0) begin
          if (left_q == REP_W'(1)) begin
            phase_q <= PH_FINISH;
          end else begin
            phase_q <= PH_SIG;
            timer_q <= sig_last_q;
            left_q  <= left_q - 1'b1;
          end
        end else begin
          timer_q <= timer_q - 1'b1;
        end
        PH_FINISH: phase_q <= PH_IDLE;
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sat_accum.sv
module sat_accum #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] acc_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] MAX_V = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] MIN_V = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] acc_q;
  logic             ovf_q;
  logic             hit_top, hit_bot;

  assign hit_top = inc_i && (acc_q == MAX_V);
  assign hit_bot = dec_i && (acc_q == MIN_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (clear_i) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (hit_top || hit_bot) ovf_q <= 1'b1;
      if (inc_i && !hit_top)      acc_q <= acc_q + 1'b1;
      else if (dec_i && !hit_bot) acc_q <= acc_q - 1'b1;
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/gated_integrator.sv
module gated_integrator
  import gated_integrator_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int WIN_W       = 24,
  parameter int REP_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIN_W-1:0] sig_len_i,
  input  logic [WIN_W-1:0] bkg_len_i,
  input  logic [REP_W-1:0] pairs_i,
  input  logic             pulse_i,
  output logic             busy_o,
  output logic             gate_o,
  output logic             count_up_o,
  output logic             done_o,
  output logic [CNT_W-1:0] result_o,
  output logic             overflow_o
);
  phase_e           phase_w;
  logic             launch_w, rise_w;
  logic [CNT_W-1:0] acc_w;
  logic [CNT_W-1:0] result_q;
  logic             done_q;

  pulse_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(pulse_i), .rise_o(rise_w)
  );

  window_seq #(.WIN_W(WIN_W), .REP_W(REP_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .sig_len_i(sig_len_i), .bkg_len_i(bkg_len_i), .pairs_i(pairs_i),
    .phase_o(phase_w), .launch_o(launch_w)
  );

  sat_accum #(.CNT_W(CNT_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(launch_w),
    .inc_i(rise_w && (phase_w == PH_SIG)),
    .dec_i(rise_w && (phase_w == PH_BKG)),
    .acc_o(acc_w), .ovf_o(overflow_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (phase_w == PH_FINISH);
      if (phase_w == PH_FINISH) result_q <= acc_w;
    end
  end

  assign busy_o     = (phase_w != PH_IDLE);
  assign gate_o     = (phase_w == PH_SIG) || (phase_w == PH_BKG);
  assign count_up_o = (phase_w == PH_SIG);
  assign done_o     = done_q;
  assign result_o   = result_q;
endmodule

// File: rtl/gated_integrator_chk.sv
module gated_integrator_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             gate,
  input logic             done,
  input logic [CNT_W-1:0] result,
  input logic             ovf,
  input logic [CNT_W-1:0] acc
);
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (acc == '0 && !ovf && busy));

  p_gate_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> busy);

  p_hold_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && !(start && !busy)) |=> $stable(acc));

  p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> (acc == $past(acc) || acc == $past(acc) + 1'b1 || acc == $past(acc) - 1'b1));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(start && !busy)) |=> ovf);
endmodule

bind gated_integrator gated_integrator_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .start(start_i), .busy(busy_o), .gate(gate_o),
  .done(done_o), .result(result_o), .ovf(overflow_o), .acc(acc_w)
);

// File: tb/gated_integrator_tb.sv
module gated_integrator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int WIN_W = 12;
  localparam int REP_W = 5;
  localparam int MAX_I = 2**(CNT_W-1) - 1;
  localparam int MIN_I = -(2**(CNT_W-1));

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [WIN_W-1:0] sig_len = '0;
  logic [WIN_W-1:0] bkg_len = '0;
  logic [REP_W-1:0] pairs = '0;
  logic             pulse = 1'b0;
  logic             busy, gate, count_up, done, overflow;
  logic [CNT_W-1:0] result;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_integrator #(.CNT_W(CNT_W), .WIN_W(WIN_W), .REP_W(REP_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sig_len_i(sig_len),
    .bkg_len_i(bkg_len), .pairs_i(pairs), .pulse_i(pulse), .busy_o(busy),
    .gate_o(gate), .count_up_o(count_up), .done_o(done), .result_o(result),
    .overflow_o(overflow)
  );

  int checks = 0;
  int errors = 0;
  int model = 0;
  bit model_ovf = 0;
  bit e1 = 0, e2 = 0, prev_p = 0;
  int sig_cyc = 0, bkg_cyc = 0;
  int pmode = 0;       // 0 quiet, 1 random density, 2 alternating, 3 bursts
  int dens = 30;
  bit start_req = 0;
  bit done_seen = 0, done_prev = 0;
  int res_seen = 0;
  bit ovf_seen = 0;
  bit cleared_pending = 0;
  bit watchdog_hit = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int sat_step(input int v, input bit up, inout bit o);
    if (up) begin
      if (v >= MAX_I) begin o = 1; return v; end
      return v + 1;
    end
    if (v <= MIN_I) begin o = 1; return v; end
    return v - 1;
  endfunction

  // One cycle: observe at the falling edge, update model, then drive.
  task automatic step();
    bit p;
    @(negedge clk);
    if (cleared_pending) begin
      check(busy == 1'b1 && overflow == 1'b0, "R1 busy/ovf after start",
            {busy, overflow}, 2);
      cleared_pending = 0;
    end
    if (!busy) check(gate == 1'b0, "R2 gate while idle", gate, 0);
    if (gate && e2) model = sat_step(model, count_up, model_ovf);
    if (gate && count_up) sig_cyc++;
    if (gate && !count_up) bkg_cyc++;
    if (done) begin
      done_seen = 1; res_seen = int'($signed(result)); ovf_seen = overflow;
    end
    if (done && done_prev) check(0, "R6 done longer than one cycle", 2, 1);
    done_prev = done;
    e2 = e1;
    case (pmode)
      1: p = ($urandom % 100) < dens;
      2: p = ~prev_p;
      3: p = (($urandom % 8) < 5);
      default: p = 0;
    endcase
    e1 = p & ~prev_p;
    prev_p = p;
    pulse = p;
    if (start_req) begin
      start = 1'b1;
      start_req = 0;
      if (!busy) begin
        model = 0; model_ovf = 0; sig_cyc = 0; bkg_cyc = 0;
        done_seen = 0; cleared_pending = 1;
      end
    end else begin
      start = 1'b0;
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      step();
      if (done_seen) begin ok = 1; break; end
    end
    if (!ok) begin
      watchdog_hit = 1;
      check(0, "R6 watchdog no done", 0, 1);
    end
  endtask

  task automatic run_meas(input int s, input int b, input int n, input int mode,
                          input int d, input bit restart_mid, input string tag);
    bit ok;
    int exp_model;
    bit exp_ovf;
    sig_len = WIN_W'(s); bkg_len = WIN_W'(b); pairs = REP_W'(n);
    pmode = mode; dens = d;
    start_req = 1;
    step();
    if (restart_mid) begin
      for (int i = 0; i < 3; i++) step();
      start_req = 1;   // R8: ignored while busy
    end
    wait_done(ok);
    if (!ok) return;
    exp_model = model; exp_ovf = model_ovf;
    check(res_seen == exp_model, {tag, " R4 result"}, res_seen, exp_model);
    check(ovf_seen == exp_ovf, {tag, " R7 overflow"}, ovf_seen, exp_ovf);
    check(sig_cyc == eff(n) * eff(s), {tag, " R2 R3 signal cycles"}, sig_cyc, eff(n) * eff(s));
    check(bkg_cyc == eff(n) * eff(b), {tag, " R2 R3 background cycles"}, bkg_cyc, eff(n) * eff(b));
    pmode = 1; dens = 50;
    for (int i = 0; i < 4; i++) step();
    check(int'($signed(result)) == exp_model, {tag, " R6 result held"},
          int'($signed(result)), exp_model);
    check(done == 1'b0 && busy == 1'b0, {tag, " R6 done strobe ended"}, {done, busy}, 0);
    pmode = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && gate == 0 && done == 0 && overflow == 0 && result == '0,
          "R1 reset state", {busy, gate, done, overflow}, 0);

    run_meas(5, 4, 1, 0, 0, 0, "quiet");
    run_meas(0, 0, 0, 2, 0, 0, "zero lengths R2 R3");
    run_meas(1, 1, 3, 2, 0, 0, "single cycle windows R4");
    run_meas(20, 20, 4, 2, 0, 0, "alternating R5");
    run_meas(30, 25, 3, 1, 40, 1, "restart ignored R8");
    run_meas(300, 1, 2, 2, 0, 0, "positive saturation R7");
    run_meas(6, 4, 2, 1, 30, 0, "after saturation R1");
    run_meas(1, 300, 2, 2, 0, 0, "negative saturation R7");
    for (int k = 0; k < 14; k++) begin
      int s, b, n, d;
      s = 1 + ($urandom % 40);
      b = 1 + ($urandom % 40);
      n = (k < 6) ? 10 + ($urandom % 11) : 1 + ($urandom % 20);
      d = $urandom % 100;
      run_meas(s, b, n, (k % 3 == 2) ? 3 : 1, d, (k % 4 == 1), "random R4");
      if (watchdog_hit) break;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule